// File: doc/BRIEF.md
# Frame-Aligned Stream Synchronization Gate

This block lets a group of eight DMA streams (four capture, four playback) start or stop on the same link frame. Software owns one 32-bit hold register on a simple register port. Each stream has a hold bit in that register. While the hold bit is set, the stream's link enable stays low. The DMA engines, FIFOs and link framer sit outside the block. Each stream feeds in its run bit, its FIFO-ready flag and a frame-start strobe from the framer. The block returns one link-enable line per stream.

To start streams together, software sets their hold bits and then sets their run bits. It waits until every FIFO reports ready, then clears all the hold bits in one write. No stream is enabled at that moment. Each released stream stays parked until its next frame-start strobe. This way, streams whose strobes arrive on the same frame boundary begin on the same frame. To stop streams together, software sets the hold bits first, which cuts transfer on the next cycle, and then clears the run bits. A stream whose hold bit is never set runs as soon as its run bit and FIFO-ready flag are high.

Top module: `ssg_gate`

## Requirements
- R1: After reset the register reads 0x00000000 and every stream is released, so each link enable equals run AND FIFO-ready.
- R2: A write stores write-data bits 7:0 as the hold bits. Read data bits 31:8 are always zero, whatever was written. The stored value appears on the read data from the cycle after the write.
- R3: Hold bit i and the inputs at index i control only link enable i. Bits 0..3 are capture streams 1..4 and bits 4..7 are playback streams 1..4.
- R4: While a stream's hold bit is 1, its link enable is 0 even with run and FIFO-ready high.
- R5: After a stream's hold bit is cleared, its link enable stays 0 until the first cycle in which that stream's frame-start strobe is high. It rises in that cycle and stays up while run and FIFO-ready remain high.
- R6: A stream whose hold bit has stayed 0 since its last release has link enable equal to run AND FIFO-ready in the same cycle, with no wait for a strobe.
- R7: A write that sets a hold bit forces that stream's link enable to 0 from the cycle after the write cycle.
- R8: A frame-start strobe that arrives while the hold bit is 1 has no effect. If the bit is cleared and set again before any strobe, the pending release is cancelled and a later clear again waits for a strobe.
- R9: Run low forces link enable low in the same cycle. Once a stream has been released, raising run again enables it at once.
- R10: FIFO-ready low forces link enable low in the same cycle.
- R11: A frame-start strobe in the same cycle as the write that clears the hold bit does not release the stream. Release waits for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the hold register |
| reg_wdata | input | 32 | Write data; bits 7:0 are the hold bits |
| reg_rdata | output | 32 | Read data: hold bits in 7:0, zero above |
| strm_run | input | 8 | Per-stream run bit from the DMA engine |
| strm_fifo_rdy | input | 8 | Per-stream FIFO-ready flag |
| strm_frame_start | input | 8 | Per-stream one-cycle frame-start strobe from the framer |
| strm_link_en | output | 8 | Per-stream permission to move data on the link |

## Verification
The assertions assume that the frame-start strobes are single-cycle pulses and that run, FIFO-ready and the register write are synchronous to the clock and stable between edges. The release assertion also assumes that a strobe marks a frame boundary, so a clear with no strobe in the same cycle must leave the stream disabled. The bench changes every input on the falling edge. It pulses strobes for exactly one cycle, and it samples one time unit after each change, so the combinational release path is seen in the strobe cycle itself.

// File: rtl/ssg_pkg.sv
// Package: shared sizes for the stream synchronization gate.
// Assumes capture streams occupy the low indices, playback streams above.
package ssg_pkg;
    localparam int SSG_NUM_CAP  = 4;   // capture (link-to-memory) streams
    localparam int SSG_NUM_PLAY = 4;   // playback (memory-to-link) streams
    localparam int SSG_REG_W    = 32;  // register port width

    // Release state of one stream lane
    typedef enum logic {
        LANE_PARKED   = 1'b0,   // waiting for a frame start after a hold
        LANE_RELEASED = 1'b1    // a frame start has been seen since the hold
    } lane_state_e;
endpackage

// File: rtl/ssg_hold_reg.sv
// Module: ssg_hold_reg
// Holds one hold bit per stream, written from the register port.
// Assumes a single-register port: every write targets this register.
// Bits above the stream count are reserved and read as zero.
module ssg_hold_reg #(
    parameter int NUM_STREAMS = 8,
    parameter int REG_W       = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wdata,
    output logic [NUM_STREAMS-1:0] hold_q,
    output logic [REG_W-1:0]       rdata
);
    localparam int RSVD_W = REG_W - NUM_STREAMS;
    localparam logic [REG_W-1:0] LIVE_MASK = {{RSVD_W{1'b0}}, {NUM_STREAMS{1'b1}}};

    // Capture hold bits on a write; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wdata[NUM_STREAMS-1:0];
        end
    end

    // Present hold bits with reserved field forced to zero
    always_comb begin
        rdata = {{RSVD_W{1'b0}}, hold_q};
    end

    // R2: read data mirrors the last write with reserved bits masked
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata == ($past(wdata) & LIVE_MASK)))
        else $error("a_r2_readback");
endmodule

// File: rtl/ssg_lane.sv
// Module: ssg_lane
// One stream's gate: tracks whether a frame start has been seen since the
// hold bit was last set and forms the link enable.
// Assumes frame_start is a one-cycle pulse at each frame boundary.
module ssg_lane
    import ssg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic run,
    input  logic fifo_rdy,
    input  logic frame_start,
    output logic link_en
);
    lane_state_e state_q;
    logic        frame_ok;

    // Park on hold; release on the first strobe seen with hold clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_RELEASED;
        end else if (hold) begin
            state_q <= LANE_PARKED;
        end else if (frame_start) begin
            state_q <= LANE_RELEASED;
        end
    end

    // Release is visible in the strobe cycle itself
    always_comb begin
        frame_ok = (state_q == LANE_RELEASED) || frame_start;
        link_en  = run && fifo_rdy && !hold && frame_ok;
    end

    // R5: a clear with no strobe in the same cycle leaves the lane off
    a_r5_wait_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold) && !hold && !frame_start) |-> !link_en)
        else $error("a_r5_wait_frame");

    // R8: a strobe seen while held does not enable the next cycle without its own strobe
    a_r8_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && frame_start) |=> (!link_en || frame_start))
        else $error("a_r8_strobe_ignored");

    // R9: run low keeps the lane off
    a_r9_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !link_en)
        else $error("a_r9_run_gate");

    // R10: FIFO not ready keeps the lane off
    a_r10_rdy_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rdy |-> !link_en)
        else $error("a_r10_rdy_gate");
endmodule

// File: rtl/ssg_gate.sv
// Module: ssg_gate (top)
// Frame-aligned stream synchronization gate for capture and playback
// streams. Assumes all inputs are synchronous to clk.
module ssg_gate
    import ssg_pkg::*;
#(
    parameter int NUM_CAP  = SSG_NUM_CAP,
    parameter int NUM_PLAY = SSG_NUM_PLAY,
    parameter int REG_W    = SSG_REG_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr_en,
    input  logic [REG_W-1:0]                reg_wdata,
    output logic [REG_W-1:0]                reg_rdata,
    input  logic [NUM_CAP+NUM_PLAY-1:0]     strm_run,
    input  logic [NUM_CAP+NUM_PLAY-1:0]     strm_fifo_rdy,
    input  logic [NUM_CAP+NUM_PLAY-1:0]     strm_frame_start,
    output logic [NUM_CAP+NUM_PLAY-1:0]     strm_link_en
);
    localparam int NUM_STREAMS = NUM_CAP + NUM_PLAY;

    logic [NUM_STREAMS-1:0] hold_q;

    ssg_hold_reg #(
        .NUM_STREAMS (NUM_STREAMS),
        .REG_W       (REG_W)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wdata  (reg_wdata),
        .hold_q (hold_q),
        .rdata  (reg_rdata)
    );

    // One gate lane per stream; capture lanes first, playback lanes above
    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
        ssg_lane u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .hold        (hold_q[i]),
            .run         (strm_run[i]),
            .fifo_rdy    (strm_fifo_rdy[i]),
            .frame_start (strm_frame_start[i]),
            .link_en     (strm_link_en[i])
        );

        // R7: a write setting this hold bit stops the stream on the next cycle
        a_r7_hold_next: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && reg_wdata[i]) |=> !strm_link_en[i])
            else $error("a_r7_hold_next");
    end
endmodule

// File: tb/ssg_gate_tb.sv
module ssg_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  strm_run;
    logic [7:0]  strm_fifo_rdy;
    logic [7:0]  strm_frame_start;
    logic [7:0]  strm_link_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    ssg_gate u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_wr_en        (reg_wr_en),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .strm_run         (strm_run),
        .strm_fifo_rdy    (strm_fifo_rdy),
        .strm_frame_start (strm_frame_start),
        .strm_link_en     (strm_link_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
    endtask

    task automatic strobe(input logic [7:0] m);
        @(negedge clk);
        strm_frame_start = m;
        #1;
    endtask

    task automatic strobe_end();
        @(negedge clk);
        strm_frame_start = '0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 link_en idle", {24'h0, strm_link_en}, 32'h0);
        @(negedge clk);
        strm_run = 8'hFF; strm_fifo_rdy = 8'hFF;
        #1;
        check("R1 released after reset", {24'h0, strm_link_en}, 32'hFF);
    endtask

    task automatic t_free_run();
        @(negedge clk);
        strm_fifo_rdy = 8'hF0;
        #1;
        check("R10 fifo not ready", {24'h0, strm_link_en}, 32'hF0);
        @(negedge clk);
        strm_fifo_rdy = 8'hFF; strm_run = 8'h5A;
        #1;
        check("R6 immediate run R3", {24'h0, strm_link_en}, 32'h5A);
        @(negedge clk);
        strm_run = 8'hFF;
        #1;
        check("R6 all running", {24'h0, strm_link_en}, 32'hFF);
    endtask

    task automatic t_reserved();
        reg_write(32'hFFFF_FF00);
        check("R2 reserved read zero", reg_rdata, 32'h0);
        check("R2 no hold from reserved", {24'h0, strm_link_en}, 32'hFF);
        reg_write(32'h1234_5600);
        check("R2 readback zero", reg_rdata, 32'h0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wdata = 32'h0000_000F;
        #1;
        check("R7 not before edge", {24'h0, strm_link_en}, 32'hFF);
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
        check("R7 R3 capture held", {24'h0, strm_link_en}, 32'hF0);
        check("R2 readback", reg_rdata, 32'h0000_000F);
        repeat (3) @(negedge clk);
        #1;
        check("R4 stays held", {24'h0, strm_link_en}, 32'hF0);
    endtask

    task automatic t_release();
        reg_write(32'h0);
        check("R5 parked after clear", {24'h0, strm_link_en}, 32'hF0);
        repeat (4) @(negedge clk);
        #1;
        check("R5 still parked", {24'h0, strm_link_en}, 32'hF0);
        strobe(8'h0F);
        check("R5 enable in strobe cycle", {24'h0, strm_link_en}, 32'hFF);
        strobe_end();
        check("R5 enable holds", {24'h0, strm_link_en}, 32'hFF);
    endtask

    task automatic t_same_cycle();
        reg_write(32'h0000_00C0);
        check("R3 playback held", {24'h0, strm_link_en}, 32'h3F);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wdata = 32'h0; strm_frame_start = 8'hC0;
        @(negedge clk);
        reg_wr_en = 1'b0; strm_frame_start = 8'h00;
        #1;
        check("R11 strobe with clear ignored", {24'h0, strm_link_en}, 32'h3F);
        strobe(8'hC0);
        check("R11 next strobe releases", {24'h0, strm_link_en}, 32'hFF);
        strobe_end();
    endtask

    task automatic t_cancel();
        reg_write(32'h0000_0030);
        reg_write(32'h0);
        reg_write(32'h0000_0030);
        strobe(8'h30);
        check("R8 strobe while held", {24'h0, strm_link_en}, 32'hCF);
        strobe_end();
        check("R8 readback", reg_rdata, 32'h0000_0030);
        reg_write(32'h0);
        check("R8 cancelled release waits", {24'h0, strm_link_en}, 32'hCF);
        strobe(8'h30);
        check("R8 released on fresh strobe", {24'h0, strm_link_en}, 32'hFF);
        strobe_end();
    endtask

    task automatic t_run();
        @(negedge clk);
        strm_run = 8'hFE;
        #1;
        check("R9 run low same cycle", {24'h0, strm_link_en}, 32'hFE);
        @(negedge clk);
        strm_run = 8'hFF;
        #1;
        check("R9 rerun after release", {24'h0, strm_link_en}, 32'hFF);
    endtask

    task automatic t_sync_stop();
        reg_write(32'h0000_00FF);
        check("R7 all held", {24'h0, strm_link_en}, 32'h0);
        @(negedge clk);
        strm_run = 8'h00;
        #1;
        reg_write(32'h0);
        check("R9 run low after clear", {24'h0, strm_link_en}, 32'h0);
        @(negedge clk);
        strm_run = 8'hFF;
        #1;
        check("R5 restart waits for frame", {24'h0, strm_link_en}, 32'h0);
        strobe(8'hFF);
        check("R5 all start together", {24'h0, strm_link_en}, 32'hFF);
        strobe_end();
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
        strm_run = '0; strm_fifo_rdy = '0; strm_frame_start = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_free_run();
        t_reserved();
        t_hold();
        t_release();
        t_same_cycle();
        t_cancel();
        t_run();
        t_sync_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule